// File: doc/BRIEF.md
# Two-Entry Elastic Pipeline Stage

This block is one stage of a latency-tolerant channel that moves data words from a producer to a consumer. The forward direction carries a valid flag with the word. The backward direction carries a stop flag. On either side, a cycle in which valid is low is idle. A cycle with valid high and stop low moves one word across. A cycle with valid and stop both high is a retry: the producer must present the same word again in the next cycle.

The stage holds up to two words. The stop flag it sends upstream comes straight from a flip-flop, so no combinational path runs from the downstream stop to the upstream stop. Because of that register, one extra word can arrive after the consumer has stalled, and the second slot catches that word. Words leave in the order they arrived.

Stages can be chained. A stall at the far end then fills the chain backwards one stage at a time, and the timing of each stage stays local.

Top module: `elastic_stage2`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `outValid` and `inStop` are both low, and the stage holds no word.
- R2: `outValid` is high in exactly those cycles in which the stage holds at least one word. A word accepted into an empty stage appears on `outData` with `outValid` high in the following cycle.
- R3: `inStop` is high exactly when the stage holds two words. It rises in the cycle after the second word is accepted while the output is stalled, and it falls in the cycle after a word leaves a full stage.
- R4: Every accepted word is delivered exactly once, in the order of acceptance. A word is accepted in a cycle with `inValid` high and `inStop` low. A word is delivered in a cycle with `outValid` high and `outStop` low.
- R5: When `outValid` and `outStop` are both high, then in the next cycle `outValid` is still high and `outData` is unchanged.
- R6: When the stage holds one word and a word is accepted and another delivered in the same cycle, the stage still holds one word afterwards. `outValid` stays high, `inStop` stays low, and the new word is the one shown on `outData`.
- R7: A cycle with `inValid` high while `inStop` is high stores nothing. The retried word is stored once, in the first cycle in which `inStop` is low.
- R8: `inStop` changes only at a clock edge. A change of `outStop` within a cycle leaves `inStop` unchanged until the next edge.
- R9: A cycle with `inValid` low stores nothing, whatever the value on `inData`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Producer presents a word |
| inData | input | DATA_W | Word from the producer |
| inStop | output | 1 | Registered back-pressure to the producer |
| outValid | output | 1 | Stage presents a word to the consumer |
| outData | output | DATA_W | Oldest stored word |
| outStop | input | 1 | Back-pressure from the consumer |

## Verification
A wrong occupancy state shows up at the ports one clock edge after the cycle that caused it. In that case `outValid` or `inStop` disagrees with a count of accepted minus delivered words, so the count is compared in every cycle. A slot loaded or promoted wrongly shows up only when the affected word is delivered. That is up to two deliveries later, which is why every delivered word is checked against an ordered model. The random traffic mixes stalls with streaming so that each of the empty, half and full transitions occurs many times, including simultaneous accept and deliver.

// File: rtl/elastic_stage2_pkg.sv
package elastic_stage2_pkg;

  typedef enum logic [1:0] {
    OCC_EMPTY = 2'd0,
    OCC_HALF  = 2'd1,
    OCC_FULL  = 2'd2
  } occ_e;

  // Strobes from the control to the datapath, valid for one clock edge
  typedef struct packed {
    logic loadHead;   // capture the input word in the head slot
    logic loadTail;   // capture the input word in the tail slot
    logic promote;    // copy the tail slot into the head slot
  } slotCtrl_t;

endpackage

// File: rtl/elastic_stage2_ctrl.sv
module elastic_stage2_ctrl
  import elastic_stage2_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      inValid,
  input  logic      outStop,
  output logic      inStop,
  output logic      outValid,
  output slotCtrl_t slotCtrl
);

  occ_e occ;
  occ_e occNext;
  logic stopReg;
  logic validReg;
  logic accept;
  logic deliver;

  assign accept  = inValid & ~stopReg;
  assign deliver = validReg & ~outStop;

  always_comb begin
    occNext  = occ;
    slotCtrl = '0;
    unique case (occ)
      OCC_EMPTY: begin
        if (accept) begin
          occNext           = OCC_HALF;
          slotCtrl.loadHead = 1'b1;
        end
      end
      OCC_HALF: begin
        unique case ({accept, deliver})
          2'b10: begin
            occNext           = OCC_FULL;
            slotCtrl.loadTail = 1'b1;
          end
          2'b01: begin
            occNext = OCC_EMPTY;
          end
          2'b11: begin
            occNext           = OCC_HALF;
            slotCtrl.loadHead = 1'b1;
          end
          default: occNext = OCC_HALF;
        endcase
      end
      OCC_FULL: begin
        if (deliver) begin
          occNext          = OCC_HALF;
          slotCtrl.promote = 1'b1;
        end
      end
      default: occNext = OCC_EMPTY;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      occ      <= OCC_EMPTY;
      stopReg  <= 1'b0;
      validReg <= 1'b0;
    end else begin
      occ      <= occNext;
      stopReg  <= (occNext == OCC_FULL);
      validReg <= (occNext != OCC_EMPTY);
    end
  end

  assign inStop   = stopReg;
  assign outValid = validReg;

endmodule

// File: rtl/elastic_stage2_data.sv
module elastic_stage2_data
  import elastic_stage2_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  slotCtrl_t         slotCtrl,
  input  logic [DATA_W-1:0] inData,
  output logic [DATA_W-1:0] outData
);

  localparam logic [DATA_W-1:0] ZERO_WORD = '0;

  logic [DATA_W-1:0] headSlot;
  logic [DATA_W-1:0] tailSlot;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      headSlot <= ZERO_WORD;
    end else if (slotCtrl.loadHead) begin
      headSlot <= inData;
    end else if (slotCtrl.promote) begin
      headSlot <= tailSlot;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tailSlot <= ZERO_WORD;
    end else if (slotCtrl.loadTail) begin
      tailSlot <= inData;
    end
  end

  assign outData = headSlot;

endmodule

// File: rtl/elastic_stage2.sv
module elastic_stage2
  import elastic_stage2_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [DATA_W-1:0] inData,
  output logic              inStop,
  output logic              outValid,
  output logic [DATA_W-1:0] outData,
  input  logic              outStop
);

  slotCtrl_t slotCtrl;

  elastic_stage2_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .outStop  (outStop),
    .inStop   (inStop),
    .outValid (outValid),
    .slotCtrl (slotCtrl)
  );

  elastic_stage2_data #(
    .DATA_W (DATA_W)
  ) i_data (
    .clk      (clk),
    .rstN     (rstN),
    .slotCtrl (slotCtrl),
    .inData   (inData),
    .outData  (outData)
  );

endmodule

// File: rtl/elastic_stage2_checker.sv
module elastic_stage2_checker #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic [DATA_W-1:0] inData,
  input logic              inStop,
  input logic              outValid,
  input logic [DATA_W-1:0] outData,
  input logic              outStop
);

  logic [1:0] heldCnt;
  logic       takeIn;
  logic       giveOut;

  assign takeIn  = inValid & ~inStop;
  assign giveOut = outValid & ~outStop;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      heldCnt <= 2'd0;
    end else begin
      heldCnt <= heldCnt + {1'b0, takeIn} - {1'b0, giveOut};
    end
  end

  // R2: output valid tracks a nonzero port-level count
  assert_valid_nonempty_R2: assert property (@(posedge clk) disable iff (!rstN)
    outValid == (heldCnt != 2'd0));

  // R3: upstream stop tracks a count of two
  assert_stop_full_R3: assert property (@(posedge clk) disable iff (!rstN)
    inStop == (heldCnt == 2'd2));

  // R4: no third word is ever taken in
  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rstN)
    heldCnt != 2'd3);

  // R5: a stalled output word is held unchanged
  assert_hold_retry_R5: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outStop) |=> (outValid && $stable(outData)));

  // R6: accept plus deliver with one word held keeps one word
  assert_half_steady_R6: assert property (@(posedge clk) disable iff (!rstN)
    (heldCnt == 2'd1 && takeIn && giveOut) |=> (outValid && !inStop));

  // R7: a retry cycle leaves the count unchanged when nothing leaves
  assert_retry_ignored_R7: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inStop && outStop) |=> inStop);

endmodule

bind elastic_stage2 elastic_stage2_checker #(.DATA_W(DATA_W)) i_checker (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .inData   (inData),
  .inStop   (inStop),
  .outValid (outValid),
  .outData  (outData),
  .outStop  (outStop)
);

// File: tb/test_elastic_stage2.sv
`timescale 1ns/1ps
module test_elastic_stage2;

  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         inValid = 1'b0;
  logic [W-1:0] inData = '0;
  logic         inStop;
  logic         outValid;
  logic [W-1:0] outData;
  logic         outStop = 1'b0;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  logic [W-1:0] expQ [0:3];
  logic [1:0]   wrPtr = '0;
  logic [1:0]   rdPtr = '0;
  int           mCount = 0;
  logic         retryPending = 1'b0;
  logic         outHeld = 1'b0;
  logic [W-1:0] outHeldData = '0;

  always #10 clk = ~clk;

  elastic_stage2 #(.DATA_W(W)) i_elastic_stage2 (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inData   (inData),
    .inStop   (inStop),
    .outValid (outValid),
    .outData  (outData),
    .outStop  (outStop)
  );

  function automatic logic expValid(input int cnt);
    return cnt != 0;
  endfunction

  function automatic logic expStop(input int cnt);
    return cnt == 2;
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [W-1:0] act,
                     input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // One channel cycle: set inputs after the falling edge, then judge the
  // handshake that the next rising edge will act on.
  task automatic step(input logic v, input logic [W-1:0] d, input logic s);
    logic doIn;
    logic doOut;
    @(negedge clk);
    if (!retryPending) begin
      inValid = v;
      inData  = d;
    end
    outStop = s;
    #1;
    if (outHeld) begin
      chk(outValid == 1'b1, "R5 valid held", {{(W-1){1'b0}}, outValid}, 1);
      chk(outData == outHeldData, "R5 data held", outData, outHeldData);
    end
    chk(outValid == expValid(mCount), "R2 outValid", {{(W-1){1'b0}}, outValid},
        {{(W-1){1'b0}}, expValid(mCount)});
    chk(inStop == expStop(mCount), "R3 inStop", {{(W-1){1'b0}}, inStop},
        {{(W-1){1'b0}}, expStop(mCount)});
    doIn  = inValid && !inStop;
    doOut = outValid && !outStop;
    if (doOut) begin
      chk(mCount > 0 && outData == expQ[rdPtr], "R4 order", outData, expQ[rdPtr]);
      rdPtr = rdPtr + 2'd1;
    end
    if (doIn) begin
      expQ[wrPtr] = inData;
      wrPtr = wrPtr + 2'd1;
    end
    mCount = mCount + (doIn ? 1 : 0) - (doOut ? 1 : 0);
    retryPending = inValid && inStop;
    outHeld = outValid && outStop;
    outHeldData = outData;
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(!outValid && !inStop, "R1 during reset", {{(W-2){1'b0}}, outValid, inStop}, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!outValid && !inStop, "R1 after reset", {{(W-2){1'b0}}, outValid, inStop}, 0);

    // R9: idle cycles with changing data store nothing
    step(1'b0, 16'hDEAD, 1'b0);
    step(1'b0, 16'hBEEF, 1'b0);
    step(1'b0, 16'h0000, 1'b0);
    chk(!outValid, "R9 idle stores nothing", {{(W-1){1'b0}}, outValid}, 0);

    // R3, R5, R7: fill while stalled, retry a third word, then drain
    step(1'b1, 16'hA001, 1'b1);
    step(1'b1, 16'hA002, 1'b1);
    step(1'b1, 16'hA003, 1'b1);
    step(1'b1, 16'hA003, 1'b1);
    chk(inStop, "R7 retry while full", {{(W-1){1'b0}}, inStop}, 1);

    // R8: a change of outStop within the cycle does not reach inStop
    @(negedge clk);
    outStop = 1'b0;
    #2;
    chk(inStop == 1'b1, "R8 no comb path", {{(W-1){1'b0}}, inStop}, 1);
    outStop = 1'b1;
    #1;
    retryPending = 1'b1;
    step(1'b1, 16'hA003, 1'b1);
    step(1'b0, 16'h0, 1'b0);
    step(1'b0, 16'h0, 1'b0);
    step(1'b0, 16'h0, 1'b0);
    step(1'b0, 16'h0, 1'b0);
    chk(!outValid, "R4 drained", {{(W-1){1'b0}}, outValid}, 0);

    // R6: streaming through a half-full stage
    step(1'b1, 16'hB000, 1'b0);
    for (int i = 1; i < 8; i++) begin
      step(1'b1, 16'hB000 + 16'(i), 1'b0);
      chk(outValid && !inStop, "R6 steady half", {{(W-2){1'b0}}, outValid, inStop}, 2);
    end
    step(1'b0, 16'h0, 1'b0);
    step(1'b0, 16'h0, 1'b0);

    // Random traffic with a fixed seed
    void'($urandom(32'd1234));
    for (int i = 0; i < 3000; i++) begin
      logic v;
      logic s;
      v = ($urandom % 4) != 0;
      s = ($urandom % 3) == 0;
      step(v, W'($urandom), s);
    end
    for (int i = 0; i < 4; i++) step(1'b0, '0, 1'b0);
    chk(mCount == 0 && !outValid, "R4 final drain", {{(W-1){1'b0}}, outValid}, 0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule